// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

The block gathers eight interrupt request lines, decides which of them the processor should serve next, and hands the processor an 8-bit vector for the winner. Software reaches it through two addresses: a command address selected when `bus_a0` is 0 and a data address selected when `bus_a0` is 1. A fixed sequence of writes sets the vector base, the cascade word and the mode. After that, data writes load the mask and command writes end interrupts or choose which status register a command read returns.

Requests are captured on rising edges into a pending register. A pending bit only counts while its line stays high. Input 0 has the highest priority. The controller raises `int_out` when an unmasked pending request outranks everything already in service. The processor answers with a one-cycle `inta` pulse. During that cycle `vec_out` carries the vector, and at the closing clock edge the winner moves from pending to in service. If the request has gone away by acknowledge time, the controller answers with the vector of input 7 and marks nothing in service.

Top module: `pic_core`

## Requirements
- R1: A command write with bit 4 set starts initialization. The next data writes are taken in order as the vector base, the cascade word, and (only when bit 0 of the start word was 1) the mode word. Command writes without bit 4 are ignored while this runs. `int_out` stays low until the sequence ends. Data writes made before the first start word are ignored.
- R2: While `inta` is high, `vec_out` equals the vector base plus the index of the acknowledged input. Without auto end-of-interrupt, that input's in-service bit is then set.
- R3: Priority is fixed, with input 0 highest. `int_out` is high exactly when some pending, unmasked request has a lower index than every set in-service bit.
- R4: After initialization, a data write loads the mask and a data read returns it. A mask bit of 1 blocks that input, so 0xFF blocks all of them.
- R5: A command write of 0x60+n (n from 0 to 7) clears in-service bit n.
- R6: After a command write of 0x0B, command reads return the in-service register. After 0x0A they return the pending register. Pending is the selection after reset and after each start word.
- R7: When bit 1 of the mode word is 1 (auto end-of-interrupt), an acknowledge sets no in-service bit.
- R8: If no unmasked pending request outranks the in-service set at acknowledge, `vec_out` is base+7 and the in-service register is unchanged. This holds whatever the mask is.
- R9: A pending bit is set by a rising edge on its line and is cleared by acknowledge or when the line goes low. A line held high after acknowledge does not request again.
- R10: Reset clears pending and in-service, sets the mask to 0xFF, selects pending for read-back, and leaves the controller waiting for a start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_a0 | input | 1 | Address select: 0 command, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address on bus_a0 |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector, valid while inta is high |

## Verification
The hardest case to reach is the spurious acknowledge. A request has to be latched and raise `int_out`, and then its line has to drop before the processor acknowledges. The bench drives exactly that: it raises line 3, lets the pending bit settle, lowers the line, and only then pulses `inta`. It then reads the in-service register back through the command address to confirm it is still empty. The same acknowledge is repeated with every input masked, which shows that the base+7 answer does not depend on the mask.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NIN = 8;
  localparam int IW  = $clog2(NIN);
  localparam int VW  = 8;

  typedef enum logic [2:0] {
    ST_WAIT_START,
    ST_WAIT_BASE,
    ST_WAIT_CASC,
    ST_WAIT_MODE,
    ST_RUN
  } init_st_t;

  localparam logic [VW-1:0] CMD_SEL_PEND = 8'h0A;
  localparam logic [VW-1:0] CMD_SEL_SERV = 8'h0B;
  localparam logic [4:0]    CMD_EOI_TOP  = 5'b01100;
  localparam int            START_BIT    = 4;
  localparam int            NEED_MODE_BIT = 0;
  localparam int            AUTO_EOI_BIT = 1;

  // isolate the lowest-index set bit (highest priority)
  function automatic logic [NIN-1:0] first_one(input logic [NIN-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // all bit positions strictly above (in priority) the best in-service bit
  function automatic logic [NIN-1:0] outrank_mask(input logic [NIN-1:0] serv);
    return first_one(serv) - 1'b1;
  endfunction

  function automatic logic [IW-1:0] oh_to_idx(input logic [NIN-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NIN; i++)
      if (oh[i]) r = r | IW'(i);
    return r;
  endfunction

  function automatic logic [VW-1:0] vec_of(input logic [VW-1:0] base,
                                           input logic [IW-1:0] idx);
    return base + VW'(idx);
  endfunction
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          a0,
  input  logic [VW-1:0] wdata,
  output logic          ready,
  output logic          init_start,
  output logic [VW-1:0] vbase,
  output logic [VW-1:0] cascade,
  output logic          aeoi,
  output logic [NIN-1:0] imr,
  output logic          rd_serv,
  output logic [NIN-1:0] eoi_oh
);
  init_st_t st;
  logic     need_mode;
  logic     cmd_wr, dat_wr;

  assign cmd_wr     = wr & ~a0;
  assign dat_wr     = wr & a0;
  assign init_start = cmd_wr & wdata[START_BIT];
  assign ready      = (st == ST_RUN);
  assign eoi_oh     = (cmd_wr && ready && wdata[7:3] == CMD_EOI_TOP)
                      ? (NIN'(1) << wdata[IW-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_WAIT_START;
      need_mode <= 1'b0;
      vbase     <= '0;
      cascade   <= '0;
      aeoi      <= 1'b0;
      imr       <= '1;
      rd_serv   <= 1'b0;
    end else if (init_start) begin
      st        <= ST_WAIT_BASE;
      need_mode <= wdata[NEED_MODE_BIT];
      aeoi      <= 1'b0;
      rd_serv   <= 1'b0;
    end else begin
      unique case (st)
        ST_WAIT_BASE: if (dat_wr) begin
          vbase <= wdata;
          st    <= ST_WAIT_CASC;
        end
        ST_WAIT_CASC: if (dat_wr) begin
          cascade <= wdata;
          st      <= need_mode ? ST_WAIT_MODE : ST_RUN;
        end
        ST_WAIT_MODE: if (dat_wr) begin
          aeoi <= wdata[AUTO_EOI_BIT];
          st   <= ST_RUN;
        end
        ST_RUN: begin
          if (dat_wr) imr <= wdata[NIN-1:0];
          else if (cmd_wr && wdata == CMD_SEL_PEND) rd_serv <= 1'b0;
          else if (cmd_wr && wdata == CMD_SEL_SERV) rd_serv <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] irq_in,
  input  logic [NIN-1:0] ack_clr,
  output logic [NIN-1:0] irr
);
  logic [NIN-1:0] prev;
  logic [NIN-1:0] rise;

  assign rise = irq_in & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      irr  <= ((irr & ~ack_clr) | rise) & irq_in;
    end
  end
endmodule

// File: rtl/pic_svc.sv
module pic_svc
  import pic_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_all,
  input  logic [NIN-1:0] eoi_oh,
  input  logic [NIN-1:0] set_oh,
  output logic [NIN-1:0] isr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       isr <= '0;
    else if (clr_all) isr <= '0;
    else              isr <= (isr & ~eoi_oh) | set_oh;
  end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  logic           ready,
  input  logic [NIN-1:0] irr,
  input  logic [NIN-1:0] imr,
  input  logic [NIN-1:0] isr,
  output logic           int_req,
  output logic [NIN-1:0] win_oh,
  output logic [IW-1:0]  win_idx
);
  logic [NIN-1:0] cand;

  assign cand    = irr & ~imr & outrank_mask(isr);
  assign win_oh  = first_one(cand);
  assign win_idx = oh_to_idx(win_oh);
  assign int_req = ready & (|cand);
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_a0,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  output logic [7:0] vec_out
);
  logic           ready, init_start, aeoi, rd_serv;
  logic [VW-1:0]  vbase, cascade;
  logic [NIN-1:0] imr, irr, isr, eoi_oh, win_oh, ack_clr, isr_set;
  logic [IW-1:0]  win_idx;
  logic           ack_go, spurious;

  pic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .a0(bus_a0), .wdata(bus_wdata),
    .ready(ready), .init_start(init_start), .vbase(vbase), .cascade(cascade),
    .aeoi(aeoi), .imr(imr), .rd_serv(rd_serv), .eoi_oh(eoi_oh)
  );

  pic_req u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_clr(ack_clr), .irr(irr)
  );

  pic_svc u_svc (
    .clk(clk), .rst_n(rst_n), .clr_all(init_start), .eoi_oh(eoi_oh),
    .set_oh(isr_set), .isr(isr)
  );

  pic_resolve u_res (
    .ready(ready), .irr(irr), .imr(imr), .isr(isr),
    .int_req(int_out), .win_oh(win_oh), .win_idx(win_idx)
  );

  assign ack_go   = inta & ready;
  assign spurious = ack_go & ~(|win_oh);
  assign ack_clr  = ack_go ? win_oh : '0;
  assign isr_set  = (ack_go && !aeoi) ? win_oh : '0;
  assign vec_out  = !ack_go ? '0
                  : vec_of(vbase, spurious ? IW'(NIN-1) : win_idx);
  assign bus_rdata = bus_a0 ? imr : (rd_serv ? isr : irr);
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
  import pic_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           init_start,
  input logic           int_out,
  input logic           inta,
  input logic           aeoi,
  input logic           spurious,
  input logic [VW-1:0]  vbase,
  input logic [VW-1:0]  cascade,
  input logic [VW-1:0]  vec_out,
  input logic [NIN-1:0] imr,
  input logic [NIN-1:0] irr,
  input logic [NIN-1:0] isr,
  input logic [NIN-1:0] win_oh,
  input logic [NIN-1:0] eoi_oh
);
  p_quiet_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  p_cascade_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !init_start) |=> $stable(cascade));

  p_single_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));

  p_winner_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh & imr) == '0);

  p_ack_marks_isr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && ready && !spurious && !aeoi && !init_start)
      |=> (isr & $past(win_oh)) != '0);

  p_eoi_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_oh != '0 && !inta) |=> (isr & $past(eoi_oh)) == '0);

  p_auto_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi) |=> (isr & ~$past(isr)) == '0);

  p_spur_no_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |=> (isr & ~$past(isr)) == '0);

  p_spur_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> vec_out == vbase + VW'(NIN-1));

  p_ack_drops_irr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && ready && !spurious) |=> (irr & $past(win_oh)) == '0);
endmodule

bind pic_core pic_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .init_start(init_start),
  .int_out(int_out), .inta(inta), .aeoi(aeoi), .spurious(spurious),
  .vbase(vbase), .cascade(cascade), .vec_out(vec_out), .imr(imr),
  .irr(irr), .isr(isr), .win_oh(win_oh), .eoi_oh(eoi_oh)
);

// File: tb/sim_pic_core.sv
module sim_pic_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_a0 = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       inta = 1'b0;
  logic [7:0] vec_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  pic_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a0(bus_a0),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .int_out(int_out), .inta(inta), .vec_out(vec_out)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a0, output logic [7:0] d);
    @(negedge clk);
    bus_a0 = a0;
    #1 d = bus_rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    inta = 1'b1;
    #1 v = vec_out;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10", "int_out after reset", {7'd0, int_out}, 8'h00);
    rd(1'b1, d); check("R10", "mask after reset", d, 8'hFF);
    rd(1'b0, d); check("R10", "pending after reset", d, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b1, d); check("R1", "data write before start ignored", d, 8'hFF);
  endtask

  task automatic t_init_mask();
    logic [7:0] d;
    wr(1'b0, 8'h11);
    set_irq(8'h08);
    check("R1", "int_out low during init", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    check("R4", "masked request hidden", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    @(negedge clk);
    check("R3", "unmasked request raises int", {7'd0, int_out}, 8'h01);
    rd(1'b1, d); check("R4", "mask readback", d, 8'h00);
    ack(d); check("R2", "vector input 3", d, 8'h23);
    wr(1'b0, 8'h63);
    set_irq(8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    set_irq(8'h24);
    ack(d); check("R3", "input 2 beats 5", d, 8'h22);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R6", "service readback", d, 8'h04);
    check("R3", "lower request blocked by service", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h62);
    rd(1'b0, d); check("R5", "eoi clears bit 2", d, 8'h00);
    check("R3", "input 5 now raises int", {7'd0, int_out}, 8'h01);
    ack(d); check("R2", "vector input 5", d, 8'h25);
    rd(1'b0, d); check("R2", "service bit 5 set", d, 8'h20);
    wr(1'b0, 8'h65);
    wr(1'b0, 8'h0A);
    set_irq(8'h00);
    set_irq(8'h02);
    rd(1'b0, d); check("R6", "pending readback", d, 8'h02);
    ack(d); check("R2", "vector input 1", d, 8'h21);
    rd(1'b0, d); check("R9", "pending cleared by ack", d, 8'h00);
    wr(1'b0, 8'h61);
    @(negedge clk);
    check("R9", "held line no re-request", {7'd0, int_out}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_spurious();
    logic [7:0] d;
    set_irq(8'h08);
    check("R3", "request latched", {7'd0, int_out}, 8'h01);
    set_irq(8'h00);
    check("R9", "pending dropped with line", {7'd0, int_out}, 8'h00);
    ack(d); check("R8", "spurious vector", d, 8'h27);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R8", "no service bit on spurious", d, 8'h00);
    wr(1'b1, 8'hFF);
    set_irq(8'h80);
    ack(d); check("R8", "spurious with all masked", d, 8'h27);
    rd(1'b0, d); check("R8", "service still empty", d, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_auto_eoi();
    logic [7:0] d;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h03);
    wr(1'b1, 8'h00);
    set_irq(8'h40);
    rd(1'b0, d); check("R6", "pending selected after restart", d, 8'h40);
    ack(d); check("R2", "new base vector", d, 8'h46);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R7", "auto eoi leaves service empty", d, 8'h00);
    set_irq(8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_mask();
    t_priority();
    t_spurious();
    t_auto_eoi();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule